// File: doc/BRIEF.md
# Escape-Sequence Print Command Decoder

This block sits between a receive byte FIFO and the print engine of a small dot-matrix printer controller. It accepts one byte at a time through a valid/ready handshake. Each byte is sorted into one of four outcomes: a printable character that is passed on, a line terminator, a vertical-tab feed, or part of an escape sequence. It also holds the live print-mode bits and the character-set selection. It counts characters against a line width supplied from outside, and it closes a full line on its own.

Requests to the engine and to the configuration unit are one-cycle pulses: flush line, feed, self-test, store settings and clear storage. Every escape command and the vertical tab first flush any characters still pending on the line. Only one cycle later do they apply their own effect. The input handshake is held off during that apply cycle.

Top module: `esc_cmd_decoder`

## Requirements
- R1: After reset, in_ready is 1, char_valid, flush_req and all request pulses are 0, print_mode is 0 and country_sel equals cfg_country.
- R2: A byte accepted with a value of 0x20 or more after masking is emitted on char_data, with char_valid high, in the cycle after acceptance. A byte below 0x20 that is none of CR (0x0D), LF (0x0A), VT (0x0B) or ESC (0x1B) produces no output.
- R3: Bit 7 of an accepted byte is cleared before it is classified, unless country_sel is 0 (full 8-bit set).
- R4: A lone CR and a lone LF each raise flush_req for one cycle. A CR followed at once by an LF, or an LF followed at once by a CR, raises it only once. Two CRs in a row flush twice.
- R5: When a printable character brings the line count up to line_width, flush_req rises in the same cycle as that character's char_valid, and the count restarts from zero.
- R6: The first terminator (or terminator pair) received right after such an automatic flush produces no flush.
- R7: ESC followed by n with n[7:4]=0 loads print_mode with n[3:0]: bit 0 double height, bit 1 double width, bit 2 graphics, bit 3 inverted. Any combination is allowed.
- R8: A dotline_done pulse clears print_mode bit 2 only. Bits 0, 1 and 3 change only through R7.
- R9: ESC ESC pulses selftest_req, ESC 0x7E pulses store_req and ESC 0x7D pulses clear_req, each for one cycle.
- R10: ESC 0x7F n with n[3:0] at most 8 makes country_sel equal n[3:0], overriding cfg_country. A value of n[3:0] above 8 discards the command.
- R11: VT (0x0B) pulses feed_req, and feed_lines reads 30.
- R12: The cycle after the final byte of an escape command or VT raises flush_req only if characters are pending. The effect follows one cycle later, and in_ready is 0 during that cycle.
- R13: A byte after ESC that is not listed in R7, R9 or R10 is discarded with no flush and no request, and decoding returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can accept a byte |
| line_width | input | CNT_W | Characters per printed line |
| cfg_country | input | 4 | Stored or jumper character-set value |
| dotline_done | input | 1 | Pulse at the end of each printed dot line |
| char_valid | output | 1 | Printable character strobe |
| char_data | output | 8 | Printable character |
| flush_req | output | 1 | Print pending line |
| feed_req | output | 1 | Feed request pulse |
| feed_lines | output | FEED_W | Dot lines to feed |
| selftest_req | output | 1 | Self-test message request |
| store_req | output | 1 | Store set and mode request |
| clear_req | output | 1 | Clear stored settings request |
| print_mode | output | 4 | {inverted, graphics, double width, double height} |
| country_sel | output | 4 | Active character set |

## Verification
The assertions assume that line_width stays constant and non-zero while a line is being filled. They also assume that dotline_done comes as isolated pulses and that in_data is stable while in_valid is high. The pairing and swallow properties only look at terminators that arrive in back-to-back cycles; gaps are left to the directed checks. The stimulus keeps line_width fixed at 4 and presents one byte at a time, with idle cycles between bytes. This lets every flush and every apply-cycle pulse be seen at its own sample point.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int MODE_W = 4;
  localparam int CSET_W = 4;
  localparam logic [CSET_W-1:0] CSET_LAST = 4'd8;

  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_VT  = 8'h0B;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_ESC = 8'h1B;
  localparam logic [7:0] CH_SP  = 8'h20;
  localparam logic [7:0] ARG_CLEAR = 8'h7D;
  localparam logic [7:0] ARG_STORE = 8'h7E;
  localparam logic [7:0] ARG_CSET  = 8'h7F;

  typedef enum logic [2:0] {BC_PRINT, BC_CR, BC_LF, BC_VT, BC_ESC, BC_OTHER} byte_class_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ESC, ST_CSET, ST_APPLY} seq_state_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_MODE, CMD_CSET, CMD_COUNTRY,
                            CMD_SELFTEST, CMD_STORE, CMD_CLEAR, CMD_FEED} cmd_e;
  typedef enum logic [1:0] {TERM_NONE, TERM_CR, TERM_LF} term_e;

  function automatic logic [7:0] mask_byte(input logic [7:0] b, input logic eight_bit);
    return eight_bit ? b : {1'b0, b[6:0]};
  endfunction

  function automatic byte_class_e classify(input logic [7:0] b);
    if (b == CH_CR)       return BC_CR;
    else if (b == CH_LF)  return BC_LF;
    else if (b == CH_VT)  return BC_VT;
    else if (b == CH_ESC) return BC_ESC;
    else if (b < CH_SP)   return BC_OTHER;
    else                  return BC_PRINT;
  endfunction

  function automatic cmd_e esc_arg_decode(input logic [7:0] b);
    if (b[7:4] == 4'h0)       return CMD_MODE;
    else if (b == CH_ESC)     return CMD_SELFTEST;
    else if (b == ARG_CSET)   return CMD_CSET;
    else if (b == ARG_STORE)  return CMD_STORE;
    else if (b == ARG_CLEAR)  return CMD_CLEAR;
    else                      return CMD_NONE;
  endfunction
endpackage

// File: rtl/esc_byte_class.sv
module esc_byte_class
  import esc_pkg::*;
(
  input  logic [7:0]  byte_in,
  input  logic        eight_bit,
  output byte_class_e cls,
  output logic [7:0]  byte_out
);
  always_comb begin
    byte_out = mask_byte(byte_in, eight_bit);
    cls      = classify(byte_out);
  end
endmodule

// File: rtl/esc_line_tracker.sv
module esc_line_tracker
  import esc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] line_width,
  input  logic             put_char,
  input  logic             is_cr,
  input  logic             is_lf,
  input  logic             other_byte,
  input  logic             clr_line,
  output logic             auto_wrap,
  output logic             term_flush,
  output logic             pending
);
  logic [CNT_W-1:0] count_q;
  logic             wrap_pend_q;
  term_e            last_q;

  function automatic logic width_hit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] w);
    return ({1'b0, c} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, w};
  endfunction

  always_comb begin
    auto_wrap  = put_char && width_hit(count_q, line_width);
    term_flush = !wrap_pend_q &&
                 ((is_cr && last_q != TERM_LF) || (is_lf && last_q != TERM_CR));
    pending    = count_q != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= '0;
      wrap_pend_q <= 1'b0;
      last_q      <= TERM_NONE;
    end else if (put_char) begin
      count_q     <= auto_wrap ? '0 : count_q + 1'b1;
      wrap_pend_q <= auto_wrap;
      last_q      <= TERM_NONE;
    end else if (is_cr || is_lf) begin
      wrap_pend_q <= 1'b0;
      if (term_flush) count_q <= '0;
      if ((is_cr && last_q == TERM_LF) || (is_lf && last_q == TERM_CR))
        last_q <= TERM_NONE;
      else
        last_q <= is_cr ? TERM_CR : TERM_LF;
    end else if (other_byte || clr_line) begin
      wrap_pend_q <= 1'b0;
      last_q      <= TERM_NONE;
      if (clr_line) count_q <= '0;
    end
  end

  assert_wrap_swallow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_wrap ##1 (is_cr || is_lf) |-> !term_flush);
  assert_pair_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cr && term_flush) ##1 is_lf |-> !term_flush);
  assert_wrap_on_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_wrap |=> !pending);
endmodule

// File: rtl/esc_mode_regs.sv
module esc_mode_regs
  import esc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              cset_we,
  input  logic [CSET_W-1:0] cset_val,
  input  logic              dotline_done,
  input  logic [CSET_W-1:0] cfg_country,
  output logic [MODE_W-1:0] print_mode,
  output logic [CSET_W-1:0] country_sel,
  output logic              eight_bit
);
  localparam int GFX_BIT = 2;

  logic [MODE_W-1:0] mode_q;
  logic [CSET_W-1:0] cset_q;
  logic              override_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      cset_q     <= '0;
      override_q <= 1'b0;
    end else begin
      if (mode_we)
        mode_q <= mode_val;
      else if (dotline_done)
        mode_q[GFX_BIT] <= 1'b0;
      if (cset_we) begin
        cset_q     <= cset_val;
        override_q <= 1'b1;
      end
    end
  end

  always_comb begin
    print_mode  = mode_q;
    country_sel = override_q ? cset_q : cfg_country;
    eight_bit   = country_sel == '0;
  end

  assert_gfx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dotline_done && !mode_we) |=> !print_mode[GFX_BIT]);
  assert_size_persist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(print_mode[1:0]) && $stable(print_mode[3]));
  assert_cset_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cset_we |-> cset_val <= CSET_LAST);
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  byte_class_e       cls,
  input  logic [7:0]        masked,
  input  logic              auto_wrap,
  input  logic              term_flush,
  input  logic              pending,
  output logic              put_char,
  output logic              is_cr,
  output logic              is_lf,
  output logic              other_byte,
  output logic              clr_line,
  output logic              char_valid,
  output logic [7:0]        char_data,
  output logic              flush_req,
  output logic              selftest_req,
  output logic              store_req,
  output logic              clear_req,
  output logic              feed_req,
  output logic              mode_we,
  output logic [MODE_W-1:0] mode_val,
  output logic              cset_we,
  output logic [CSET_W-1:0] cset_val
);
  seq_state_e       state_q, state_d;
  cmd_e             cmd_q, cmd_d;
  logic [3:0]       arg_q;
  logic             accept, idle_acc, cmd_start;
  cmd_e             arg_cmd;

  always_comb begin
    in_ready = state_q != ST_APPLY;
    accept   = in_valid && in_ready;
    idle_acc = accept && state_q == ST_IDLE;
    put_char = idle_acc && cls == BC_PRINT;
    is_cr    = idle_acc && cls == BC_CR;
    is_lf    = idle_acc && cls == BC_LF;
    other_byte = accept && !(put_char || is_cr || is_lf);
    arg_cmd  = esc_arg_decode(in_data);
    state_d  = state_q;
    cmd_d    = CMD_NONE;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (cls == BC_ESC) state_d = ST_ESC;
        else if (cls == BC_VT) begin
          cmd_d = CMD_FEED; state_d = ST_APPLY;
        end
      end
      ST_ESC: if (accept) begin
        if (arg_cmd == CMD_CSET) state_d = ST_CSET;
        else if (arg_cmd == CMD_NONE) state_d = ST_IDLE;
        else begin
          cmd_d = arg_cmd; state_d = ST_APPLY;
        end
      end
      ST_CSET: if (accept) begin
        if (in_data[3:0] <= CSET_LAST) begin
          cmd_d = CMD_COUNTRY; state_d = ST_APPLY;
        end else state_d = ST_IDLE;
      end
      ST_APPLY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    cmd_start = cmd_d != CMD_NONE;
    clr_line  = cmd_start;
    mode_we   = state_q == ST_APPLY && cmd_q == CMD_MODE;
    mode_val  = arg_q;
    cset_we   = state_q == ST_APPLY && cmd_q == CMD_COUNTRY;
    cset_val  = arg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cmd_q        <= CMD_NONE;
      arg_q        <= '0;
      char_valid   <= 1'b0;
      char_data    <= '0;
      flush_req    <= 1'b0;
      selftest_req <= 1'b0;
      store_req    <= 1'b0;
      clear_req    <= 1'b0;
      feed_req     <= 1'b0;
    end else begin
      state_q    <= state_d;
      char_valid <= put_char;
      if (put_char) char_data <= masked;
      flush_req  <= auto_wrap || term_flush || (cmd_start && pending);
      if (cmd_start) begin
        cmd_q <= cmd_d;
        arg_q <= in_data[3:0];
      end
      selftest_req <= state_q == ST_APPLY && cmd_q == CMD_SELFTEST;
      store_req    <= state_q == ST_APPLY && cmd_q == CMD_STORE;
      clear_req    <= state_q == ST_APPLY && cmd_q == CMD_CLEAR;
      feed_req     <= state_q == ST_APPLY && cmd_q == CMD_FEED;
    end
  end

  assert_apply_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_APPLY |=> state_q == ST_IDLE && in_ready);
  assert_req_after_apply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (selftest_req || store_req || clear_req || feed_req) |-> $past(state_q == ST_APPLY));
  assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({selftest_req, store_req, clear_req, feed_req}));
  assert_unlisted_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ESC && accept && arg_cmd == CMD_NONE) |=> !flush_req && state_q == ST_IDLE);
endmodule

// File: rtl/esc_cmd_decoder.sv
module esc_cmd_decoder
  import esc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FEED_W     = 6,
  parameter int FEED_LINES = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  line_width,
  input  logic [3:0]        cfg_country,
  input  logic              dotline_done,
  output logic              char_valid,
  output logic [7:0]        char_data,
  output logic              flush_req,
  output logic              feed_req,
  output logic [FEED_W-1:0] feed_lines,
  output logic              selftest_req,
  output logic              store_req,
  output logic              clear_req,
  output logic [3:0]        print_mode,
  output logic [3:0]        country_sel
);
  byte_class_e       cls;
  logic [7:0]        masked;
  logic              eight_bit;
  logic              put_char, is_cr, is_lf, other_byte, clr_line;
  logic              auto_wrap, term_flush, pending;
  logic              mode_we, cset_we;
  logic [MODE_W-1:0] mode_val;
  logic [CSET_W-1:0] cset_val;

  assign feed_lines = FEED_W'(FEED_LINES);

  esc_byte_class u_class (
    .byte_in(in_data), .eight_bit(eight_bit), .cls(cls), .byte_out(masked)
  );

  esc_line_tracker #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_width(line_width),
    .put_char(put_char), .is_cr(is_cr), .is_lf(is_lf),
    .other_byte(other_byte), .clr_line(clr_line),
    .auto_wrap(auto_wrap), .term_flush(term_flush), .pending(pending)
  );

  esc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cls(cls), .masked(masked),
    .auto_wrap(auto_wrap), .term_flush(term_flush), .pending(pending),
    .put_char(put_char), .is_cr(is_cr), .is_lf(is_lf),
    .other_byte(other_byte), .clr_line(clr_line),
    .char_valid(char_valid), .char_data(char_data), .flush_req(flush_req),
    .selftest_req(selftest_req), .store_req(store_req), .clear_req(clear_req),
    .feed_req(feed_req), .mode_we(mode_we), .mode_val(mode_val),
    .cset_we(cset_we), .cset_val(cset_val)
  );

  esc_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .cset_we(cset_we), .cset_val(cset_val), .dotline_done(dotline_done),
    .cfg_country(cfg_country), .print_mode(print_mode),
    .country_sel(country_sel), .eight_bit(eight_bit)
  );
endmodule

// File: tb/esc_cmd_decoder_tb.sv
module esc_cmd_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [7:0] line_width = 8'd4;
  logic [3:0] cfg_country = 4'd1;
  logic       dotline_done = 1'b0;
  logic       char_valid, flush_req, feed_req, selftest_req, store_req, clear_req;
  logic [7:0] char_data;
  logic [5:0] feed_lines;
  logic [3:0] print_mode, country_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  esc_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_width(line_width), .cfg_country(cfg_country),
    .dotline_done(dotline_done), .char_valid(char_valid), .char_data(char_data),
    .flush_req(flush_req), .feed_req(feed_req), .feed_lines(feed_lines),
    .selftest_req(selftest_req), .store_req(store_req), .clear_req(clear_req),
    .print_mode(print_mode), .country_sel(country_sel)
  );

  // entry: {byte, char_valid, char, flush, events{feed,clear,store,selftest}}
  localparam int NV = 29;
  localparam logic [21:0] VEC [NV] = '{
    {8'h41, 1'b1, 8'h41, 1'b0, 4'h0},  // R2 printable
    {8'h0D, 1'b0, 8'h00, 1'b1, 4'h0},  // R4 CR
    {8'h0A, 1'b0, 8'h00, 1'b0, 4'h0},  // R4 CR LF pair
    {8'h0A, 1'b0, 8'h00, 1'b1, 4'h0},  // R4 lone LF
    {8'h0D, 1'b0, 8'h00, 1'b0, 4'h0},  // R4 LF CR pair
    {8'h0D, 1'b0, 8'h00, 1'b1, 4'h0},  // R4 CR
    {8'h0D, 1'b0, 8'h00, 1'b1, 4'h0},  // R4 CR CR
    {8'h57, 1'b1, 8'h57, 1'b0, 4'h0},
    {8'h58, 1'b1, 8'h58, 1'b0, 4'h0},
    {8'h59, 1'b1, 8'h59, 1'b0, 4'h0},
    {8'h5A, 1'b1, 8'h5A, 1'b1, 4'h0},  // R5 wrap
    {8'h0D, 1'b0, 8'h00, 1'b0, 4'h0},  // R6 swallowed
    {8'h0A, 1'b0, 8'h00, 1'b0, 4'h0},  // R6 swallowed pair
    {8'h0A, 1'b0, 8'h00, 1'b1, 4'h0},  // R4 lone LF
    {8'hC1, 1'b1, 8'h41, 1'b0, 4'h0},  // R3 masked
    {8'h05, 1'b0, 8'h00, 1'b0, 4'h0},  // R2 dropped
    {8'h1B, 1'b0, 8'h00, 1'b0, 4'h0},
    {8'h1B, 1'b0, 8'h00, 1'b1, 4'h1},  // R9 R12 selftest with flush
    {8'h1B, 1'b0, 8'h00, 1'b0, 4'h0},
    {8'h7E, 1'b0, 8'h00, 1'b0, 4'h2},  // R9 store
    {8'h1B, 1'b0, 8'h00, 1'b0, 4'h0},
    {8'h7D, 1'b0, 8'h00, 1'b0, 4'h4},  // R9 clear
    {8'h0B, 1'b0, 8'h00, 1'b0, 4'h8},  // R11 feed
    {8'h42, 1'b1, 8'h42, 1'b0, 4'h0},
    {8'h0B, 1'b0, 8'h00, 1'b1, 4'h8},  // R11 R12 flush then feed
    {8'h43, 1'b1, 8'h43, 1'b0, 4'h0},
    {8'h1B, 1'b0, 8'h00, 1'b0, 4'h0},
    {8'h40, 1'b0, 8'h00, 1'b0, 4'h0},  // R13 discarded
    {8'h0D, 1'b0, 8'h00, 1'b1, 4'h0}   // R13 idle again, R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic cv, output logic [7:0] cd,
                      output logic fl, output logic [3:0] ev);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cv = char_valid; cd = char_data; fl = flush_req;
    @(posedge clk);
    @(negedge clk);
    ev = {feed_req, clear_req, store_req, selftest_req};
  endtask

  task automatic send_quiet(input logic [7:0] b);
    logic cv, fl;
    logic [7:0] cd;
    logic [3:0] ev;
    send(b, cv, cd, fl, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic cv, fl;
    logic [7:0] cd;
    logic [3:0] ev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 outputs", {char_valid, flush_req, feed_req, selftest_req, store_req, clear_req}, 0);
    chk("R1 mode", print_mode, 0);
    chk("R1 country", country_sel, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][21:14], cv, cd, fl, ev);
      chk($sformatf("R2 char_valid vec%0d", i), cv, VEC[i][13]);
      if (VEC[i][13]) chk($sformatf("R2 char_data vec%0d", i), cd, VEC[i][12:5]);
      chk($sformatf("R4 R5 R6 flush vec%0d", i), fl, VEC[i][4]);
      chk($sformatf("R9 R11 events vec%0d", i), ev, VEC[i][3:0]);
    end

    // R12 in_ready low during apply cycle
    send_quiet(8'h1B);
    @(negedge clk);
    in_data = 8'h7E; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 in_ready apply", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R12 store after apply", store_req, 1);
    chk("R12 in_ready back", in_ready, 1);

    // R7 mode setting
    send_quiet(8'h1B); send_quiet(8'h0F);
    chk("R7 mode all", print_mode, 4'hF);
    // R8 dot line end clears graphics only
    @(negedge clk) dotline_done = 1'b1;
    @(negedge clk) dotline_done = 1'b0;
    chk("R8 graphics cleared", print_mode, 4'hB);
    send_quiet(8'h1B); send_quiet(8'h05);
    chk("R7 mode combo", print_mode, 4'h5);
    @(negedge clk) dotline_done = 1'b1;
    @(negedge clk) dotline_done = 1'b0;
    chk("R8 size persists", print_mode, 4'h1);

    // R10 country selection
    send_quiet(8'h1B); send_quiet(8'h7F); send(8'h09, cv, cd, fl, ev);
    chk("R10 out of range ignored", country_sel, 1);
    chk("R10 no flush", {fl, ev}, 0);
    send_quiet(8'h1B); send_quiet(8'h7F); send_quiet(8'h00);
    chk("R10 full set", country_sel, 0);
    send(8'hC1, cv, cd, fl, ev);
    chk("R3 eight bit kept", cd, 8'hC1);
    send_quiet(8'h1B); send_quiet(8'h7F); send_quiet(8'h13);
    chk("R10 german", country_sel, 3);
    cfg_country = 4'd5;
    @(negedge clk);
    chk("R10 override holds", country_sel, 3);

    // R11 feed length
    chk("R11 feed_lines", feed_lines, 30);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule